// File: doc/BRIEF.md
# Host-to-DSP Split-Word Mailbox

This block passes a 31-bit message in one direction, from a host processor to a DSP. Each side sees the message as two 16-bit words. The host first writes the upper word, which carries message bits 30..16. It then writes the lower word, which carries bits 15..0. Writing the lower word publishes the message and raises a "mail waiting" flag. The flag occupies bit 15 of the upper word as the DSP reads it.

The DSP polls the flag in the upper word. When the flag is set, it reads the upper word and then the lower word. Reading the lower word clears the flag. An upper word written by the host is held in a staging register until the lower word arrives. The DSP therefore never sees a half-updated message.

A one-cycle pulse marks each publication, so it can drive an interrupt. The flag is also brought out directly. For traffic in the other direction, a second instance can be used with the roles of the two sides swapped.

Top module: `xfer_mailbox`

## Requirements
- R1: After reset the flag output is 0, the publish pulse is 0 and the DSP read data is 0.
- R2: A host write of the upper word (`hostWrSel`=0) only loads the staging register. It changes neither the flag nor the upper word the DSP reads.
- R3: A host write of the lower word (`hostWrSel`=1) does three things at the next edge. It copies the staging register into the visible upper word, loads the visible lower word, and sets the flag to 1.
- R4: A DSP read at the lower address (default 0xFFFF) clears the flag at the next edge. The visible message words stay unchanged.
- R5: A DSP read at the upper address (default 0xFFFE) leaves the flag unchanged.
- R6: If a host lower-word write and a DSP lower-word read happen in the same cycle, the flag ends up 1. That read returns the lower word as it was before the write.
- R7: `newMail` is 1 for exactly the cycle after each host lower-word write, and 0 otherwise.
- R8: Read data is registered. One edge after a read, `dspRdData` holds one of two formats:
  - for the upper address: {flag, message bits 30..16};
  - for the lower address: message bits 15..0.
- R9: A read at any other address returns 0 and has no effect. While `dspRdEn` is 0, `dspRdData` holds its value and the flag is not cleared.
- R10: Bit 15 of a host upper-word write is discarded. Only bits 14..0 are staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrSel | input | 1 | 0 selects the upper word, 1 the lower word |
| hostWrData | input | 16 | Host write data |
| dspRdEn | input | 1 | DSP read strobe |
| dspRdAddr | input | 16 | DSP register address |
| dspRdData | output | 16 | Registered DSP read data |
| mailFull | output | 1 | Flag: a message is waiting |
| newMail | output | 1 | One-cycle pulse on publication |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it:
- the read data for a DSP read;
- the flag after a lower-word write or a lower-word read;
- the publish pulse.

The driver computes each expected value from a model of the requirements. It stamps the value with the cycle number in which it is due. The monitor compares each value at the falling edge of that cycle, midway between register updates.

The sequence exercises the ordering cases: an upper-word write while the flag is set, a simultaneous write and read of the lower word, back-to-back publications, and reads at foreign addresses and with the strobe low.

// File: rtl/xfer_mailbox_pkg.sv
package xfer_mailbox_pkg;

  typedef struct packed {
    logic stageHi;   // load staging register from host data
    logic publish;   // move staging + host data into visible words
    logic capHi;     // capture {flag, visible upper} into read register
    logic capLo;     // capture visible lower into read register
    logic capZero;   // capture zero (foreign address)
  } mboxStrobes_t;

endpackage

// File: rtl/xfer_mailbox_ctrl.sv
module xfer_mailbox_ctrl
  import xfer_mailbox_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'hFFFE,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostWrSel,
  input  logic              dspRdEn,
  input  logic [ADDR_W-1:0] dspRdAddr,
  output mboxStrobes_t      strobes,
  output logic              mailFull,
  output logic              newMail
);

  logic hitHi;
  logic hitLo;
  logic lowWrite;
  logic lowRead;
  logic flagNext;

  assign hitHi    = dspRdEn && (dspRdAddr == HI_ADDR);
  assign hitLo    = dspRdEn && (dspRdAddr == LO_ADDR);
  assign lowWrite = hostWrEn && hostWrSel;
  assign lowRead  = hitLo;

  always_comb begin
    strobes.stageHi = hostWrEn && !hostWrSel;
    strobes.publish = lowWrite;
    strobes.capHi   = hitHi;
    strobes.capLo   = hitLo;
    strobes.capZero = dspRdEn && !hitHi && !hitLo;
  end

  // Write has priority over the clearing read.
  always_comb begin
    flagNext = mailFull;
    if (lowRead)  flagNext = 1'b0;
    if (lowWrite) flagNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mailFull <= 1'b0;
      newMail  <= 1'b0;
    end else begin
      mailFull <= flagNext;
      newMail  <= lowWrite;
    end
  end

endmodule

// File: rtl/xfer_mailbox_datapath.sv
module xfer_mailbox_datapath
  import xfer_mailbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobes_t      strobes,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              mailFull,
  output logic [DATA_W-1:0] dspRdData
);

  localparam int HI_PAY_W = DATA_W - 1;

  logic [HI_PAY_W-1:0] stageHi;
  logic [HI_PAY_W-1:0] visHi;
  logic [DATA_W-1:0]   visLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageHi <= '0;
      visHi   <= '0;
      visLo   <= '0;
    end else begin
      if (strobes.stageHi) stageHi <= hostWrData[HI_PAY_W-1:0];
      if (strobes.publish) begin
        visHi <= stageHi;
        visLo <= hostWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dspRdData <= '0;
    end else if (strobes.capHi) begin
      dspRdData <= {mailFull, visHi};
    end else if (strobes.capLo) begin
      dspRdData <= visLo;
    end else if (strobes.capZero) begin
      dspRdData <= '0;
    end
  end

endmodule

// File: rtl/xfer_mailbox.sv
module xfer_mailbox
  import xfer_mailbox_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'hFFFE,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostWrSel,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              dspRdEn,
  input  logic [ADDR_W-1:0] dspRdAddr,
  output logic [DATA_W-1:0] dspRdData,
  output logic              mailFull,
  output logic              newMail
);

  mboxStrobes_t strobes;

  xfer_mailbox_ctrl #(
    .ADDR_W (ADDR_W),
    .HI_ADDR(HI_ADDR),
    .LO_ADDR(LO_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .hostWrSel(hostWrSel),
    .dspRdEn  (dspRdEn),
    .dspRdAddr(dspRdAddr),
    .strobes  (strobes),
    .mailFull (mailFull),
    .newMail  (newMail)
  );

  xfer_mailbox_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostWrData(hostWrData),
    .mailFull  (mailFull),
    .dspRdData (dspRdData)
  );

endmodule

// File: rtl/xfer_mailbox_checker.sv
module xfer_mailbox_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'hFFFE,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'hFFFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic              hostWrSel,
  input logic              dspRdEn,
  input logic [ADDR_W-1:0] dspRdAddr,
  input logic [DATA_W-1:0] dspRdData,
  input logic              mailFull,
  input logic              newMail
);

  logic wrLo;
  logic wrHi;
  logic rdLo;
  logic rdHi;
  logic rdOther;

  assign wrLo    = hostWrEn && hostWrSel;
  assign wrHi    = hostWrEn && !hostWrSel;
  assign rdLo    = dspRdEn && (dspRdAddr == LO_ADDR);
  assign rdHi    = dspRdEn && (dspRdAddr == HI_ADDR);
  assign rdOther = dspRdEn && !rdLo && !rdHi;

  assert_upper_write_keeps_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && !rdLo) |=> $stable(mailFull));

  assert_low_write_sets_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrLo |=> mailFull);

  assert_low_read_clears_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdLo && !wrLo) |=> !mailFull);

  assert_upper_read_keeps_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdHi && !wrLo) |=> $stable(mailFull));

  assert_pulse_after_publish_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrLo |=> newMail);

  assert_no_pulse_without_publish_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrLo |=> !newMail);

  assert_upper_read_shows_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdHi |=> (dspRdData[DATA_W-1] == $past(mailFull)));

  assert_foreign_read_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdOther && !wrLo) |=> (dspRdData == '0 && $stable(mailFull)));

  assert_idle_read_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!dspRdEn && !wrLo) |=> ($stable(dspRdData) && $stable(mailFull)));

endmodule

bind xfer_mailbox xfer_mailbox_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .HI_ADDR(HI_ADDR),
  .LO_ADDR(LO_ADDR)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .hostWrEn (hostWrEn),
  .hostWrSel(hostWrSel),
  .dspRdEn  (dspRdEn),
  .dspRdAddr(dspRdAddr),
  .dspRdData(dspRdData),
  .mailFull (mailFull),
  .newMail  (newMail)
);

// File: tb/xfer_mailbox_bench.sv
`timescale 1ns/1ps
module xfer_mailbox_bench;

  localparam logic [15:0] HI_A = 16'hFFFE;
  localparam logic [15:0] LO_A = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic        hostWrSel = 1'b0;
  logic [15:0] hostWrData = '0;
  logic        dspRdEn = 1'b0;
  logic [15:0] dspRdAddr = '0;
  logic [15:0] dspRdData;
  logic        mailFull;
  logic        newMail;

  always #10 clk = ~clk;  // 50 MHz

  xfer_mailbox u_xfer_mailbox (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrEn  (hostWrEn),
    .hostWrSel (hostWrSel),
    .hostWrData(hostWrData),
    .dspRdEn   (dspRdEn),
    .dspRdAddr (dspRdAddr),
    .dspRdData (dspRdData),
    .mailFull  (mailFull),
    .newMail   (newMail)
  );

  typedef struct {
    int          due;
    int          kind;  // 0 read data, 1 flag, 2 pulse
    logic [15:0] val;
    string       req;
  } item_t;

  item_t q[$];
  item_t it;
  int    cycleCount = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Requirement model
  logic        mFlag = 1'b0;
  logic [14:0] mStage = '0;
  logic [14:0] mHi = '0;
  logic [15:0] mLo = '0;

  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic report(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: compare results in the cycle they are due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cycleCount) begin
      it = q.pop_front();
      case (it.kind)
        0: report(it.req, "rdData", dspRdData, it.val);
        1: report(it.req, "flag", {15'd0, mailFull}, it.val);
        default: report(it.req, "pulse", {15'd0, newMail}, it.val);
      endcase
    end
  end

  // Driver: one bus cycle, pushes expected results due one edge later
  task automatic step(input logic wEn, input logic wSel, input logic [15:0] wData,
                      input logic rEn, input logic [15:0] rAddr, input string req);
    logic lowWr, hiWr, lowRd, hiRd, nextFlag;
    item_t e;
    @(posedge clk);
    #2;
    hostWrEn = wEn; hostWrSel = wSel; hostWrData = wData;
    dspRdEn = rEn; dspRdAddr = rAddr;
    lowWr = wEn && wSel;
    hiWr  = wEn && !wSel;
    lowRd = rEn && rAddr == LO_A;
    hiRd  = rEn && rAddr == HI_A;
    e.due = cycleCount + 1;
    e.req = req;
    if (rEn) begin
      e.kind = 0;
      e.val  = hiRd ? {mFlag, mHi} : (lowRd ? mLo : 16'h0000);
      q.push_back(e);
    end
    nextFlag = lowWr ? 1'b1 : (lowRd ? 1'b0 : mFlag);
    e.kind = 1; e.val = {15'd0, nextFlag}; q.push_back(e);
    e.kind = 2; e.val = {15'd0, lowWr};    q.push_back(e);
    if (lowWr) begin
      mHi = mStage;
      mLo = wData;
    end
    if (hiWr) mStage = wData[14:0];
    mFlag = nextFlag;
  endtask

  task automatic idle(input string req);
    step(1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    report("R1", "flag", {15'd0, mailFull}, 16'h0000);
    report("R1", "pulse", {15'd0, newMail}, 16'h0000);
    report("R1", "rdData", dspRdData, 16'h0000);
    @(posedge clk); #2; rstN = 1'b1;

    idle("R1");
    // R10: bit 15 of the upper write is dropped; R2: staged only
    step(1'b1, 1'b0, 16'hFABC, 1'b0, 16'h0000, "R10");
    step(1'b0, 1'b0, 16'h0000, 1'b1, HI_A, "R2");
    // R3 publish, R7 pulse
    step(1'b1, 1'b1, 16'h1234, 1'b0, 16'h0000, "R3");
    step(1'b0, 1'b0, 16'h0000, 1'b1, HI_A, "R8");
    step(1'b0, 1'b0, 16'h0000, 1'b1, HI_A, "R5");
    // R9: foreign address and idle strobe
    step(1'b0, 1'b0, 16'h0000, 1'b1, 16'hFFFD, "R9");
    step(1'b0, 1'b0, 16'h0000, 1'b0, LO_A, "R9");
    // R2: upper write while full leaves visible word alone
    step(1'b1, 1'b0, 16'h0001, 1'b0, 16'h0000, "R2");
    step(1'b0, 1'b0, 16'h0000, 1'b1, HI_A, "R2");
    // R4: lower read clears flag, data remains
    step(1'b0, 1'b0, 16'h0000, 1'b1, LO_A, "R4");
    step(1'b0, 1'b0, 16'h0000, 1'b1, HI_A, "R4");
    step(1'b0, 1'b0, 16'h0000, 1'b1, LO_A, "R4");
    // R6: simultaneous lower write and lower read
    step(1'b1, 1'b1, 16'hBEEF, 1'b1, LO_A, "R6");
    step(1'b0, 1'b0, 16'h0000, 1'b1, HI_A, "R6");
    step(1'b0, 1'b0, 16'h0000, 1'b1, LO_A, "R8");
    // R7: back-to-back publications
    step(1'b1, 1'b0, 16'h2AAA, 1'b0, 16'h0000, "R7");
    step(1'b1, 1'b1, 16'h5555, 1'b0, 16'h0000, "R7");
    step(1'b1, 1'b1, 16'hA5A5, 1'b0, 16'h0000, "R7");
    idle("R7");
    step(1'b0, 1'b0, 16'h0000, 1'b1, HI_A, "R3");
    step(1'b0, 1'b0, 16'h0000, 1'b1, LO_A, "R3");
    idle("R9");
    idle("R9");
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule